// File: doc/BRIEF.md
# Loopback Self-Test Engine

This block is a built-in self-test engine for a four-lane serial link controller. It produces a stream of 32-bit test words and sends it out on any chosen subset of the lane transmit paths, one word per clock. It then compares the words that come back from one chosen lane with a locally regenerated copy of the stream. The test word is either a fixed word that software programs or a pseudorandom sequence from a 31-bit LFSR with taps x^31 + x^28 + 1.

Software drives the engine through two 32-bit registers: a control word at byte offset 0x50 and a fixed-word register at 0x54. Turning the run bit on seeds both generators and clears all results. While the run bit stays on, the engine transmits and compares. Turning the run bit off stops transmission and freezes the results. Three status outputs report the outcome: a sticky error flag, a saturating count of mismatched words, and a count of compared words.

The compare side is a three-state machine. ST_IDLE moves to ST_SYNC when the run bit rises. ST_SYNC moves to ST_TRACK on the first accepted beat from the selected lane. ST_SYNC and ST_TRACK both return to ST_IDLE when the run bit is low. A rising run bit forces ST_SYNC from any state.

Top module: `lbist_engine`

## Requirements
- R1: After reset, both registers read 0, all transmit valids are 0, and the error flag and both counters are 0.
- R2: The control word at 0x50 and the fixed word at 0x54 read back every bit written, including the reserved bits 29:18 and 15:4. Any other offset reads 0.
- R3: Control bit 31 is the run bit and bits 3:0 are the lane mask, bit i for lane i. Starting one clock after a control write, tx_valid equals the mask when the run bit is 1. Data of lanes that are not valid is 0.
- R4: When control bit 30 is 1, every valid transmit beat carries the current fixed word.
- R5: When control bit 30 is 0, the beats form a PRBS stream. The LFSR state s (31 bits) is loaded with SEED when the run bit rises, and it advances by one word per clock while running. Each word is built over 32 steps, first bit in the MSB. At each step, b = s[30]^s[27], the word takes b, and s becomes {s[29:0], b}.
- R6: Writing the run bit to 0 drops all tx_valid bits on the clock after the write.
- R7: Only the lane named by control bits 17:16 is compared. Beats and errors on the other lanes have no effect on the results.
- R8: Each accepted beat that differs from the expected word sets the sticky error flag and increments mismatch_cnt, which saturates at 0xFFFF.
- R9: beat_cnt counts every accepted beat from the selected lane. The checker's generator advances only on accepted beats, so a clean loopback of any latency gives zero mismatches.
- R10: A control write that changes the run bit from 0 to 1 clears the flag and both counters. A write that keeps the run bit at 1 leaves them unchanged.
- R11: If the selected lane is not in the mask, beat_cnt stays 0 and no error is flagged.
- R12: While the run bit is 0, loopback beats are ignored and the results hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| tx_data | output | 128 | Transmit word for each lane, lane i at bits 32i+31:32i |
| tx_valid | output | 4 | Transmit valid for each lane |
| lb_data | input | 128 | Loopback word for each lane, same packing |
| lb_valid | input | 4 | Loopback valid for each lane |
| bist_err | output | 1 | Sticky mismatch flag |
| mismatch_cnt | output | 16 | Saturating count of mismatched words |
| beat_cnt | output | 32 | Count of compared words |

## Verification
A control write takes effect at the clock edge that samples it. The first transmit beat, or the drop of the valids, appears one edge later. The bench therefore samples tx_valid and tx_data on the falling edge that follows the second rising edge after it drives the write. Counters update on the edge that samples a loopback beat. The bench models a three-stage loopback pipe and waits until that pipe is empty before it reads the counters. It stops traffic by clearing the lane mask while the run bit stays on, so every beat in flight is still compared. For the PRBS words, the bench steps its own model of the LFSR, one step per expected beat.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int          WORD_W    = 32;
    localparam int          LFSR_W    = 31;
    localparam logic [7:0]  OFS_CTRL  = 8'h50;
    localparam logic [7:0]  OFS_FIXED = 8'h54;
    localparam int          BIT_RUN   = 31;
    localparam int          BIT_FIXED = 30;
    localparam int          SEL_LSB   = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_TRACK
    } chk_state_t;

    // Steps the x^31 + x^28 + 1 register 32 times, returning {state, word}.
    function automatic logic [LFSR_W+WORD_W-1:0] prbs_step(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] t;
        logic [WORD_W-1:0] w;
        logic              b;
        t = s;
        w = '0;
        for (int i = 0; i < WORD_W; i++) begin
            b = t[30] ^ t[27];
            w = {w[WORD_W-2:0], b};
            t = {t[LFSR_W-2:0], b};
        end
        return {t, w};
    endfunction

endpackage

// File: rtl/lbist_regs.sv
module lbist_regs
    import lbist_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] ctrl,
    output logic [WORD_W-1:0] fixed_word,
    output logic              run_rise
);

    logic hit_ctrl;
    logic hit_fixed;

    assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
    assign hit_fixed = (addr == ADDR_W'(OFS_FIXED));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            fixed_word <= '0;
        end else if (we) begin
            if (hit_ctrl)  ctrl       <= wdata;
            if (hit_fixed) fixed_word <= wdata;
        end
    end

    assign run_rise = we && hit_ctrl && wdata[BIT_RUN] && !ctrl[BIT_RUN];

    always_comb begin
        rdata = '0;
        if (hit_ctrl)  rdata = ctrl;
        if (hit_fixed) rdata = fixed_word;
    end

endmodule

// File: rtl/lbist_prbs.sv
module lbist_prbs
    import lbist_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 31'h2A5C_0F13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    output logic [WORD_W-1:0] word
);

    logic [LFSR_W-1:0]        state;
    logic [LFSR_W+WORD_W-1:0] step;

    assign step = prbs_step(state);
    assign word = step[WORD_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)      state <= SEED;
        else if (load)   state <= SEED;
        else if (adv)    state <= step[LFSR_W+WORD_W-1:WORD_W];
    end

endmodule

// File: rtl/lbist_check.sv
module lbist_check
    import lbist_pkg::*;
#(
    parameter int ERR_W = 16,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              run_rise,
    input  logic              beat_valid,
    input  logic [WORD_W-1:0] beat_data,
    input  logic [WORD_W-1:0] expected,
    output logic              accept,
    output logic              err_flag,
    output logic [ERR_W-1:0]  err_cnt,
    output logic [CNT_W-1:0]  cmp_cnt
);

    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    chk_state_t state, state_nxt;
    logic       miss;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (run_rise) begin
            state_nxt = ST_SYNC;
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_SYNC:  if (!run) state_nxt = ST_IDLE;
                          else if (beat_valid) state_nxt = ST_TRACK;
                ST_TRACK: if (!run) state_nxt = ST_IDLE;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        accept = 1'b0;
        unique case (state)
            ST_IDLE:  accept = 1'b0;
            ST_SYNC,
            ST_TRACK: accept = run && beat_valid;
            default:  accept = 1'b0;
        endcase
        miss = accept && (beat_data != expected);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || run_rise) begin
            err_flag <= 1'b0;
            err_cnt  <= '0;
            cmp_cnt  <= '0;
        end else begin
            if (accept) cmp_cnt <= cmp_cnt + 1'b1;
            if (miss) begin
                err_flag <= 1'b1;
                if (err_cnt != ERR_MAX) err_cnt <= err_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
    import lbist_pkg::*;
#(
    parameter int                NPORTS = 4,
    parameter int                ADDR_W = 8,
    parameter int                ERR_W  = 16,
    parameter int                CNT_W  = 32,
    parameter logic [LFSR_W-1:0] SEED   = 31'h2A5C_0F13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [WORD_W-1:0]        reg_wdata,
    output logic [WORD_W-1:0]        reg_rdata,
    output logic [NPORTS*WORD_W-1:0] tx_data,
    output logic [NPORTS-1:0]        tx_valid,
    input  logic [NPORTS*WORD_W-1:0] lb_data,
    input  logic [NPORTS-1:0]        lb_valid,
    output logic                     bist_err,
    output logic [ERR_W-1:0]         mismatch_cnt,
    output logic [CNT_W-1:0]         beat_cnt
);

    localparam int SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] fixed_word;
    logic              run_rise;
    logic              run;
    logic              use_fixed;
    logic [SEL_W-1:0]  sel;
    logic [WORD_W-1:0] tx_prbs;
    logic [WORD_W-1:0] chk_prbs;
    logic [WORD_W-1:0] tx_word;
    logic [WORD_W-1:0] expected;
    logic              sel_valid;
    logic [WORD_W-1:0] sel_data;
    logic              accept;

    assign run       = ctrl[BIT_RUN];
    assign use_fixed = ctrl[BIT_FIXED];
    assign sel       = ctrl[SEL_LSB +: SEL_W];
    assign tx_word   = use_fixed ? fixed_word : tx_prbs;
    assign expected  = use_fixed ? fixed_word : chk_prbs;
    assign sel_valid = lb_valid[sel];
    assign sel_data  = lb_data[sel*WORD_W +: WORD_W];

    lbist_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .ctrl       (ctrl),
        .fixed_word (fixed_word),
        .run_rise   (run_rise)
    );

    lbist_prbs #(.SEED(SEED)) u_tx_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (run_rise),
        .adv   (run),
        .word  (tx_prbs)
    );

    lbist_prbs #(.SEED(SEED)) u_chk_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (run_rise),
        .adv   (accept),
        .word  (chk_prbs)
    );

    lbist_check #(.ERR_W(ERR_W), .CNT_W(CNT_W)) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .run_rise   (run_rise),
        .beat_valid (sel_valid),
        .beat_data  (sel_data),
        .expected   (expected),
        .accept     (accept),
        .err_flag   (bist_err),
        .err_cnt    (mismatch_cnt),
        .cmp_cnt    (beat_cnt)
    );

    for (genvar g = 0; g < NPORTS; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tx_valid[g]                  <= 1'b0;
                tx_data[g*WORD_W +: WORD_W] <= '0;
            end else begin
                tx_valid[g]                  <= run && ctrl[g];
                tx_data[g*WORD_W +: WORD_W] <= (run && ctrl[g]) ? tx_word : '0;
            end
        end
    end

endmodule

// File: rtl/lbist_engine_sva.sv
module lbist_engine_sva
    import lbist_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ERR_W  = 16,
    parameter int CNT_W  = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [WORD_W-1:0]        ctrl,
    input logic [WORD_W-1:0]        fixed_word,
    input logic                     run_rise,
    input logic [NPORTS-1:0]        tx_valid,
    input logic [NPORTS*WORD_W-1:0] tx_data,
    input logic                     bist_err,
    input logic [ERR_W-1:0]         mismatch_cnt,
    input logic [CNT_W-1:0]         beat_cnt
);

    p_tx_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[BIT_RUN] |=> tx_valid == $past(ctrl[NPORTS-1:0]));

    p_tx_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[BIT_RUN] |=> tx_valid == '0);

    p_fixed_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid[0] && $past(ctrl[BIT_FIXED])) |-> tx_data[WORD_W-1:0] == $past(fixed_word));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_err && !run_rise) |=> bist_err);

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch_cnt == '1 && !run_rise) |=> mismatch_cnt == '1);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run_rise |=> (beat_cnt == '0 && mismatch_cnt == '0 && !bist_err));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[BIT_RUN] && !run_rise) |=> $stable(beat_cnt) && $stable(mismatch_cnt));

endmodule

bind lbist_engine lbist_engine_sva #(
    .NPORTS (NPORTS),
    .ERR_W  (ERR_W),
    .CNT_W  (CNT_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl         (ctrl),
    .fixed_word   (fixed_word),
    .run_rise     (run_rise),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .bist_err     (bist_err),
    .mismatch_cnt (mismatch_cnt),
    .beat_cnt     (beat_cnt)
);

// File: tb/lbist_engine_test.sv
`timescale 1ns/1ps
module lbist_engine_test;

    localparam int          NP   = 4;
    localparam int          W    = 32;
    localparam logic [30:0] SEED = 31'h2A5C_0F13;
    localparam int          LAT  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NP*W-1:0] tx_data;
    logic [NP-1:0]   tx_valid;
    logic [NP*W-1:0] lb_data;
    logic [NP-1:0]   lb_valid;
    logic            bist_err;
    logic [15:0]     mismatch_cnt;
    logic [31:0]     beat_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // loopback pipe with optional bit-0 corruption per lane
    logic [NP*W-1:0] p_d [LAT];
    logic [NP-1:0]   p_v [LAT];
    int              inj_req  [NP];
    int              inj_done [NP];
    logic [NP*W-1:0] flip;
    bit              manual = 0;
    logic [NP*W-1:0] man_d = '0;
    logic [NP-1:0]   man_v = '0;
    int              seen2 = 0;

    always #10 clk = ~clk;

    lbist_engine #(.NPORTS(NP), .SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .lb_data(lb_data), .lb_valid(lb_valid),
        .bist_err(bist_err), .mismatch_cnt(mismatch_cnt), .beat_cnt(beat_cnt)
    );

    initial for (int i = 0; i < NP; i++) inj_req[i] = 0;

    always_comb begin
        flip = '0;
        for (int i = 0; i < NP; i++)
            flip[i*W] = tx_valid[i] && (inj_done[i] < inj_req[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) inj_done[i] <= 0;
            for (int k = 0; k < LAT; k++) begin p_d[k] <= '0; p_v[k] <= '0; end
        end else begin
            for (int i = 0; i < NP; i++)
                if (flip[i*W]) inj_done[i] <= inj_done[i] + 1;
            p_d[0] <= tx_data ^ flip;
            p_v[0] <= tx_valid;
            for (int k = 1; k < LAT; k++) begin p_d[k] <= p_d[k-1]; p_v[k] <= p_v[k-1]; end
        end
    end

    assign lb_data  = manual ? man_d : p_d[LAT-1];
    assign lb_valid = manual ? man_v : p_v[LAT-1];

    always @(negedge clk) if (lb_valid[2]) seen2 <= seen2 + 1;

    function automatic logic [31:0] m_word(input logic [30:0] s);
        logic [30:0] t = s;
        logic [31:0] w = '0;
        for (int i = 0; i < 32; i++) begin
            w = {w[30:0], t[30] ^ t[27]};
            t = {t[29:0], t[30] ^ t[27]};
        end
        return w;
    endfunction

    function automatic logic [30:0] m_next(input logic [30:0] s);
        logic [30:0] t = s;
        for (int i = 0; i < 32; i++) t = {t[29:0], t[30] ^ t[27]};
        return t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h50, v);  check("R1 ctrl", v, 0);
        rd(8'h54, v);  check("R1 fixed", v, 0);
        check("R1 tx_valid", 32'(tx_valid), 0);
        check("R1 counters", {bist_err, mismatch_cnt, beat_cnt[14:0]}, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(8'h50, 32'h3FFC_FFF0); rd(8'h50, v); check("R2 ctrl reserved", v, 32'h3FFC_FFF0);
        wr(8'h54, 32'hDEAD_BEEF); rd(8'h54, v); check("R2 fixed", v, 32'hDEAD_BEEF);
        rd(8'h58, v); check("R2 other offset", v, 0);
        wr(8'h50, 32'h0);
    endtask

    task automatic t_prbs_tx;
        logic [30:0] s = SEED;
        wr(8'h50, 32'h8000_0001);
        @(posedge clk); @(negedge clk);
        check("R3 mask lane0", 32'(tx_valid), 32'h1);
        for (int k = 0; k < 4; k++) begin
            check("R5 prbs word", tx_data[31:0], m_word(s));
            s = m_next(s);
            @(negedge clk);
        end
        wr(8'h50, 32'h0);
        check("R6 still valid one edge", 32'(tx_valid), 32'h1);
        @(negedge clk);
        check("R6 valid dropped", 32'(tx_valid), 0);
        idle(6);
    endtask

    task automatic t_fixed_tx;
        wr(8'h54, 32'hC3A5_0FF0);
        wr(8'h50, 32'hC000_000A);
        @(posedge clk); @(negedge clk);
        check("R3 mask 1010", 32'(tx_valid), 32'hA);
        check("R4 lane1 fixed", tx_data[63:32], 32'hC3A5_0FF0);
        check("R4 lane3 fixed", tx_data[127:96], 32'hC3A5_0FF0);
        check("R3 lane0 idle data", tx_data[31:0], 0);
        wr(8'h50, 32'h0);
        @(negedge clk);
        check("R6 fixed stop", 32'(tx_valid), 0);
        idle(6);
    endtask

    task automatic t_loop;
        int base, held;
        base = seen2;
        inj_req[0] = inj_done[0] + 5;
        inj_req[2] = inj_done[2] + 3;
        wr(8'h50, 32'h8002_0005);
        idle(200);
        wr(8'h50, 32'h8002_0000);
        idle(LAT + 4);
        check("R9 beat count", beat_cnt, seen2 - base);
        check("R8 three mismatches", 32'(mismatch_cnt), 3);
        check("R8 flag", 32'(bist_err), 1);
        check("R7 lane0 errors ignored", 32'(mismatch_cnt), 3);
        wr(8'h50, 32'h8002_0000);
        check("R10 keep-on write no clear", 32'(mismatch_cnt), 3);
        held = beat_cnt;
        wr(8'h50, 32'h0002_0000);
        manual = 1; man_v = 4'h4; man_d = '0;
        idle(10);
        man_v = '0; manual = 0;
        check("R12 idle beats ignored", beat_cnt, held);
        wr(8'h50, 32'h8002_0005);
        check("R10 clear on rise", {bist_err, mismatch_cnt, beat_cnt[14:0]}, 0);
        idle(100);
        wr(8'h50, 32'h8002_0000);
        idle(LAT + 4);
        check("R9 clean loop", 32'(mismatch_cnt), 0);
        check("R9 clean loop count nonzero", 32'(beat_cnt > 0), 1);
        wr(8'h50, 32'h0);
    endtask

    task automatic t_unselected;
        wr(8'h50, 32'h8003_0003);
        idle(50);
        wr(8'h50, 32'h8003_0000);
        idle(LAT + 4);
        check("R11 no beats", beat_cnt, 0);
        check("R11 no error", 32'(bist_err), 0);
        wr(8'h50, 32'h0);
    endtask

    task automatic t_saturate;
        wr(8'h54, 32'h0);
        wr(8'h50, 32'hC000_0000);
        manual = 1; man_d = '0; man_d[0] = 1'b1; man_v = 4'h1;
        idle(65540);
        man_v = '0;
        idle(2);
        check("R8 saturate", 32'(mismatch_cnt), 32'hFFFF);
        check("R9 count past saturation", 32'(beat_cnt >= 65536), 1);
        manual = 0;
        wr(8'h50, 32'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_prbs_tx();
        t_fixed_tx();
        t_loop();
        t_unselected();
        t_saturate();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule